// File: doc/BRIEF.md
# Serial Flash Command Launcher

This block is the register front end of a serial flash controller. A host writes a 24-bit flash address, a command register and transmit data words over a simple write port. The command register has two fields: a data-length field and an instruction-code field. Writing the instruction-code field is the launch. If the block can take the command, it drives one single-lane SPI frame: the instruction byte, then the address, then any data bytes the command needs.

Data for program commands comes from a 15-word circular transmit buffer. The host can fill it before launch and keep filling it while the frame runs. If the buffer runs dry in the middle of the data phase, the serial clock stops and the frame waits with chip select still held. The host sees three status outputs: buffer-not-empty, a count of words written since the last clear, and busy. A launch that cannot be accepted is dropped with no side effect.

Top module: `sfl_cmd_launcher`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, busy is 0, txne is 0 and wr_count is 0.
- R2: Register select 1 is the command register, with the instruction code in wr_data[7:0] (byte lane 0) and the data length in bytes in wr_data[23:16] (byte lane 2). A write on lane 2 alone stores the length and starts nothing. A write that includes lane 0 launches. A write that carries both lanes launches with the new length.
- R3: A frame holds cs_n low throughout. It sends the 8-bit instruction, then the 24-bit address from register select 0 (wr_data[23:0]), all MSB first. mosi is stable while sck is high, and sck idles low.
- R4: Instruction 8'h02 is the program instruction. After the address, it sends as many data bytes as the length field holds, taken from the buffer. Each word goes out from bit 31 downward, and a final partial word sends only its upper bytes. Every other code sends no data bytes.
- R5: A launch write made while busy is 1 is ignored, including its length lane.
- R6: A launch write of the program instruction while the buffer is empty is ignored.
- R7: The buffer holds 15 words in first-in first-out order. A push (register select 2) into a full buffer is dropped.
- R8: txne is 1 exactly when the buffer holds at least one word. A partly sent word still leaves the buffer.
- R9: wr_count rises by one for each accepted push and is not reduced when words are sent. Writing 1 to wr_data[0] of register select 3 on lane 0 empties the buffer and zeros wr_count.
- R10: If the buffer is empty when a program frame needs its next word, sck stays low and cs_n stays low until a word is pushed. The frame then continues with no lost or repeated bits.
- R11: busy is 1 from the edge that accepts a launch until the frame ends. cs_n returns high for at least one cycle between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 command, 2 transmit data, 3 control |
| wr_be | input | 4 | Byte-lane enables |
| wr_data | input | 32 | Write data |
| txne | output | 1 | Transmit buffer not empty |
| wr_count | output | CNT_W | Words written since last clear |
| busy | output | 1 | Command frame in progress |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |

## Verification
A wrong buffer pointer or count shows up on mosi as a misordered, repeated or missing data byte within the next data word of a program frame. It also shows up at once on txne after pushes or a clear. A faulty launch gate shows as an extra frame, or as busy rising in the cycle after a write that should have been dropped. A wrong shift or bit counter corrupts the header bytes of the very next frame, or leaves a byte that is not whole when cs_n rises.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_TXD  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2,
    ST_END   = 2'd3
  } shf_state_e;

  localparam logic [7:0] PROG_CODE = 8'h02;
endpackage

// File: rtl/sfl_txbuf.sv
module sfl_txbuf #(
  parameter int DEPTH = 15,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         push_acc
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop_acc;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign push_acc = push && !full && !clr;
  assign pop_acc  = pop && !empty && !clr;
  assign rdata    = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_acc) wp_d = wrap_inc(wp_q);
      if (pop_acc)  rp_d = wrap_inc(rp_q);
      case ({push_acc, pop_acc})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_acc && (wp_q == PW'(i))) mem_q[i] <= wdata;
    end
  end

  // R7: a push into a full buffer never grows the occupancy past DEPTH
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);
  // R10: the serial engine only takes a word that is present
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/sfl_shifter.sv
module sfl_shifter
  import sfl_pkg::*;
#(
  parameter int HALF  = 2,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       start_instr,
  input  logic [23:0]      start_addr,
  input  logic [LEN_W-1:0] start_len,
  input  logic             buf_empty,
  input  logic [31:0]      buf_rdata,
  output logic             buf_pop,
  output logic             busy,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi
);
  localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;

  shf_state_e       state_q, state_d;
  logic [31:0]      sreg_q, sreg_d;
  logic [5:0]       bits_q, bits_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             ph_q, ph_d;
  logic [HC_W-1:0]  hc_q, hc_d;
  logic             half_end;

  assign half_end = (hc_q == HC_W'(HALF - 1));

  always_comb begin
    state_d = state_q;
    sreg_d  = sreg_q;
    bits_d  = bits_q;
    rem_d   = rem_q;
    ph_d    = ph_q;
    hc_d    = hc_q;
    buf_pop = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          sreg_d  = {start_instr, start_addr};
          bits_d  = 6'd32;
          rem_d   = start_len;
          ph_d    = 1'b0;
          hc_d    = '0;
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (half_end) begin
          hc_d = '0;
          ph_d = ~ph_q;
          if (ph_q) begin
            sreg_d = {sreg_q[30:0], 1'b0};
            bits_d = bits_q - 1'b1;
            if (bits_q == 6'd1) state_d = (rem_q == '0) ? ST_END : ST_LOAD;
          end
        end else begin
          hc_d = hc_q + 1'b1;
        end
      end
      ST_LOAD: begin
        if (!buf_empty) begin
          buf_pop = 1'b1;
          sreg_d  = buf_rdata;
          if (rem_q >= LEN_W'(4)) begin
            bits_d = 6'd32;
            rem_d  = rem_q - LEN_W'(4);
          end else begin
            bits_d = {rem_q[2:0], 3'b000};
            rem_d  = '0;
          end
          state_d = ST_SHIFT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sreg_q  <= '0;
      bits_q  <= '0;
      rem_q   <= '0;
      ph_q    <= 1'b0;
      hc_q    <= '0;
    end else begin
      state_q <= state_d;
      sreg_q  <= sreg_d;
      bits_q  <= bits_d;
      rem_q   <= rem_d;
      ph_q    <= ph_d;
      hc_q    <= hc_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign cs_n = (state_q == ST_IDLE) || (state_q == ST_END);
  assign sck  = (state_q == ST_SHIFT) && ph_q;
  assign mosi = sreg_q[31];

  // R3: data only moves while sck is low
  p_mosi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  // R3: clock pulses only occur inside a selected frame
  p_sck_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);
  // R11: a frame end always leaves a deselected cycle
  p_frame_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_END) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/sfl_cmd_launcher.sv
module sfl_cmd_launcher
  import sfl_pkg::*;
#(
  parameter int DEPTH = 15,
  parameter int CNT_W = 16,
  parameter int HALF  = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  output logic             txne,
  output logic [CNT_W-1:0] wr_count,
  output logic             busy,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi
);
  localparam int LEN_W = 8;

  logic rst_meta_q, rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic [23:0]      addr_q, addr_d;
  logic [LEN_W-1:0] len_q, len_d, len_use;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             launch_req, launch_ok, len_wr, is_prog;
  logic             clr_req, push_req, push_acc;
  logic             buf_empty, buf_full, buf_pop;
  logic [31:0]      buf_rdata;

  assign launch_req = wr_en && (wr_sel == SEL_CMD) && wr_be[0];
  assign len_wr     = wr_en && (wr_sel == SEL_CMD) && wr_be[2];
  assign is_prog    = (wr_data[7:0] == PROG_CODE);
  assign launch_ok  = launch_req && !busy && !(is_prog && buf_empty);
  assign clr_req    = wr_en && (wr_sel == SEL_CTRL) && wr_be[0] && wr_data[0];
  assign push_req   = wr_en && (wr_sel == SEL_TXD);
  assign len_use    = len_wr ? wr_data[23:16] : len_q;

  always_comb begin
    addr_d = addr_q;
    len_d  = len_q;
    cnt_d  = cnt_q;
    if (wr_en && (wr_sel == SEL_ADDR)) addr_d = wr_data[23:0];
    if (len_wr && (!launch_req || launch_ok)) len_d = wr_data[23:16];
    if (clr_req)       cnt_d = '0;
    else if (push_acc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_d;
      len_q  <= len_d;
      cnt_q  <= cnt_d;
    end
  end

  sfl_txbuf #(.DEPTH(DEPTH), .W(32)) u_txbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_req),
    .push     (push_req),
    .wdata    (wr_data),
    .pop      (buf_pop),
    .rdata    (buf_rdata),
    .empty    (buf_empty),
    .full     (buf_full),
    .push_acc (push_acc)
  );

  sfl_shifter #(.HALF(HALF), .LEN_W(LEN_W)) u_shifter (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (launch_ok),
    .start_instr (wr_data[7:0]),
    .start_addr  (addr_q),
    .start_len   (is_prog ? len_use : '0),
    .buf_empty   (buf_empty),
    .buf_rdata   (buf_rdata),
    .buf_pop     (buf_pop),
    .busy        (busy),
    .sck         (sck),
    .cs_n        (cs_n),
    .mosi        (mosi)
  );

  assign txne     = !buf_empty;
  assign wr_count = cnt_q;

  // R11: an accepted launch makes the engine busy on the next cycle
  p_busy_after_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ok |=> busy);
  // R6: program launch on an empty buffer leaves the engine idle
  p_empty_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_req && is_prog && !txne && !busy) |=> !busy);
  // R9: a clear zeroes the written-word counter
  p_count_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (wr_count == '0));
  // R8: a clear empties the buffer
  p_clear_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !txne);
  // R7: a full buffer does not report more accepted pushes
  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && buf_full && !clr_req) |=> $stable(wr_count));
endmodule

// File: tb/sfl_cmd_launcher_tb.sv
`timescale 1ns/1ps
module sfl_cmd_launcher_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic        txne, busy, sck, cs_n, mosi;
  logic [15:0] wr_count;

  int checks = 0;
  int errors = 0;
  int frames_exp = 0;
  int frames_seen = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rx_byte = 8'h00;
  int rx_bits = 0;
  int base_cnt;

  always #2.5 clk = ~clk;

  sfl_cmd_launcher u_dut (
    .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
    .wr_data(wr_data), .txne(txne), .wr_count(wr_count), .busy(busy),
    .sck(sck), .cs_n(cs_n), .mosi(mosi)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0;
  endtask

  task automatic exp_hdr(input logic [7:0] code, input logic [23:0] a);
    exp_q.push_back(code);
    exp_q.push_back(a[23:16]);
    exp_q.push_back(a[15:8]);
    exp_q.push_back(a[7:0]);
    frames_exp++;
  endtask

  task automatic exp_data(input logic [31:0] w, input int nb);
    for (int k = 0; k < nb; k++) exp_q.push_back(w[31-8*k -: 8]);
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor: collect bits on rising sck, compare whole bytes
  always @(posedge sck) begin
    if (!cs_n) begin
      rx_byte = {rx_byte[6:0], mosi};
      rx_bits++;
      if (rx_bits == 8) begin
        rx_bits = 0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected byte", {24'h0, rx_byte}, 32'h0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_byte == e, "R3/R4 frame byte", {24'h0, rx_byte}, {24'h0, e});
        end
      end
    end
  end

  always @(posedge cs_n) begin
    if (rst_ni === 1'b1) begin
      frames_seen++;
      chk(rx_bits == 0, "R3 whole bytes per frame", rx_bits, 0);
      rx_bits = 0;
    end
  end

  initial begin
    #(150000 * 5);
    $display("FAIL watchdog: got timeout expected completion");
    errors++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wr_en = 1'b0; wr_sel = 2'd0; wr_be = 4'h0; wr_data = '0;
    rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(cs_n == 1'b1 && sck == 1'b0, "R1 cs_n/sck", {cs_n, sck}, 2'b10);
    chk(busy == 1'b0 && txne == 1'b0, "R1 busy/txne", {busy, txne}, 0);
    chk(wr_count == 0, "R1 wr_count", wr_count, 0);

    // R3 non-program command: header only, address upper bits ignored
    wr(2'd0, 4'hF, 32'hFF12_3456);
    exp_hdr(8'h20, 24'h123456);
    wr(2'd1, 4'h1, 32'h0000_0020);
    chk(busy == 1'b1, "R11 busy after launch", busy, 1);
    // R5 launch while busy is dropped
    wr(2'd1, 4'h5, 32'h0004_00D8);
    wait_idle();
    chk(frames_seen == 1, "R5 no extra frame", frames_seen, 1);
    chk(exp_q.size() == 0, "R3 header complete", exp_q.size(), 0);

    // R2 length-only write does not launch
    wr(2'd1, 4'h4, 32'h0003_0000);
    chk(busy == 1'b0, "R2 options-only no launch", busy, 0);
    wr(2'd2, 4'hF, 32'hA1B2_C3D4);
    chk(wr_count == 1, "R9 count after push", wr_count, 1);
    chk(txne == 1'b1, "R8 txne set", txne, 1);
    wr(2'd0, 4'hF, 32'h0000_0100);
    exp_hdr(8'h02, 24'h000100);
    exp_data(32'hA1B2_C3D4, 3);
    wr(2'd1, 4'h1, 32'h0000_0002);
    wait_idle();
    chk(txne == 1'b0, "R8 partial word leaves buffer", txne, 0);
    chk(wr_count == 1, "R9 count not reduced by send", wr_count, 1);
    chk(frames_seen == 2, "R2 stored length launch", frames_seen, 2);

    // R6 program on empty buffer ignored
    wr(2'd1, 4'h1, 32'h0000_0002);
    chk(busy == 1'b0, "R6 empty program ignored", busy, 0);
    repeat (20) @(negedge clk);
    chk(frames_seen == 2 && cs_n == 1'b1, "R6 no frame", frames_seen, 2);

    // R2/R4 combined write, two words, six bytes
    wr(2'd2, 4'hF, 32'h1122_3344);
    wr(2'd2, 4'hF, 32'h5566_7788);
    exp_hdr(8'h02, 24'h000100);
    exp_data(32'h1122_3344, 4);
    exp_data(32'h5566_7788, 2);
    wr(2'd1, 4'h5, 32'h0006_0002);
    chk(busy == 1'b1, "R2 combined write launches", busy, 1);
    wait_idle();
    chk(txne == 1'b0, "R8 drained", txne, 0);

    // R10 stall when buffer runs dry
    wr(2'd2, 4'hF, 32'hCAFE_F00D);
    exp_hdr(8'h02, 24'h000100);
    exp_data(32'hCAFE_F00D, 4);
    exp_data(32'h0BAD_BEEF, 4);
    wr(2'd1, 4'h5, 32'h0008_0002);
    repeat (300) @(negedge clk);
    chk(busy == 1'b1 && cs_n == 1'b0 && sck == 1'b0, "R10 paused in frame",
        {busy, cs_n, sck}, 3'b100);
    wr(2'd2, 4'hF, 32'h0BAD_BEEF);
    wait_idle();
    chk(frames_seen == 4, "R10 frame resumed", frames_seen, 4);

    // R9 clear
    base_cnt = wr_count;
    wr(2'd2, 4'hF, 32'h1);
    wr(2'd2, 4'hF, 32'h2);
    wr(2'd2, 4'hF, 32'h3);
    chk(wr_count == base_cnt + 3, "R9 count increments", wr_count, base_cnt + 3);
    wr(2'd3, 4'h1, 32'h0000_0001);
    chk(txne == 1'b0, "R9 clear empties buffer", txne, 0);
    chk(wr_count == 0, "R9 clear zeros count", wr_count, 0);

    // R7 fill past capacity, then drain all in order across the wrap
    for (int i = 0; i < 16; i++) wr(2'd2, 4'hF, 32'h0000_0100 + i);
    chk(wr_count == 15, "R7 extra push dropped", wr_count, 15);
    wr(2'd0, 4'hF, 32'h00AB_CDEF);
    exp_hdr(8'h02, 24'hABCDEF);
    for (int i = 0; i < 15; i++) exp_data(32'h0000_0100 + i, 4);
    wr(2'd1, 4'h5, 32'h003C_0002);
    wait_idle();
    chk(txne == 1'b0, "R7 all fifteen sent", txne, 0);

    chk(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
    chk(frames_seen == frames_exp, "R11 frame count", frames_seen, frames_exp);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule